// File: doc/BRIEF.md
# Error-Correction Engine Register Front End

This block is the register and interrupt front end of a NAND-flash error-correction engine with one encode channel and one decode channel. Software reaches it through a simple memory-mapped port with single-cycle write and read strobes. Through that port it starts and stops each channel, programs a configuration word per channel, reads idle flags, enables interrupts and reads interrupt status, a per-sector decode-done mask and the encoder's parity words.

The configuration words are passed unchanged to the codec core. Inside this block the core is replaced by a stub. For each sector the stub holds the channel busy for `STEP_CYCLES` cycles and then reports that sector done. The decode channel handles `NUM_SECTORS` sectors per run and the encode channel handles one. Decode status clears when it is read. The interrupt can fire once per correction step, or once per page when the page-select bit is set.

Top module: `ecc_regfront`

## Requirements
- R1: After reset both channels are stopped and idle: the control reads 0, the idle flags (bit 0 of 0x00C and 0x10C) read 1, and the interrupt enables, statuses, done mask, parity words and configuration outputs are all zero with `irq_o` low.
- R2: Writing 1 to bit 0 of a control register (encode 0x000, decode 0x100) starts an idle channel, and its idle flag reads 0 on the next cycle. Writing 0 stops the channel at once: the idle flag returns to 1 and the control reads 0. Bit 0 of the control stays 1 after a run completes, until software writes 0.
- R3: A configuration write (encode 0x004, decode 0x104) is stored whole, read back unchanged and driven on `enc_cfg_o`/`dec_cfg_o`. The fields are: strength index in bits 4:0, mode from bit 5, message length in bits from bit 16, correction enable in bits 13:12 and empty-page detect in bit 31.
- R4: A configuration write that arrives while its channel is busy is ignored.
- R5: While decoding, sector k sets bit k of the done mask (0x124) once `STEP_CYCLES` cycles have passed for that sector. All `NUM_SECTORS` bits are set when the run ends, and the mask clears when a new run starts.
- R6: `irq_o` is the OR, over both channels, of enable bit 0 (0x080 / 0x200) ANDed with that channel's pending status. Status becomes pending even while the enable is 0.
- R7: With page-select (enable bit 1) clear, decode status becomes pending after every sector. With it set, status becomes pending only after the last sector.
- R8: Reading the decode status (0x204, bit 0) returns the pending bit and clears it. Reading the done mask also clears that pending bit.
- R9: Encode status (0x084, bit 0) sets when the encoder's sector finishes. Reads do not clear it; stopping or starting the channel does. Bit 1 of 0x00C reads 1 once the run has finished. Parity word i at 0x010+4i then reads the encode configuration XOR (i+1)*0x01010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Combined interrupt |
| enc_cfg_o | output | 32 | Encode configuration word to the codec core |
| dec_cfg_o | output | 32 | Decode configuration word to the codec core |

## Verification
On every cycle, assertions check four things: a busy channel keeps its configuration word, the done mask never loses a bit during a run and is empty when a run starts, page mode raises pending only once the last sector is done, and the interrupt never fires without a pending status. The bench scenarios are the only way to show the cycle-level timing and the register interactions. These cover the sector-by-sector mask growth, clearing by a status read versus a done-mask read, enabling an interrupt after its status is already pending, aborting a run mid-sector, and the encoder's parity words together with its sticky status.

// File: rtl/ecc_regfront_pkg.sv
package ecc_regfront_pkg;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_ENC_CTL  = 12'h000;
  localparam logic [AW-1:0] A_ENC_CFG  = 12'h004;
  localparam logic [AW-1:0] A_ENC_IDLE = 12'h00C;
  localparam logic [AW-1:0] A_ENC_PAR  = 12'h010;
  localparam logic [AW-1:0] A_ENC_IEN  = 12'h080;
  localparam logic [AW-1:0] A_ENC_STA  = 12'h084;
  localparam logic [AW-1:0] A_DEC_CTL  = 12'h100;
  localparam logic [AW-1:0] A_DEC_CFG  = 12'h104;
  localparam logic [AW-1:0] A_DEC_IDLE = 12'h10C;
  localparam logic [AW-1:0] A_DEC_DONE = 12'h124;
  localparam logic [AW-1:0] A_DEC_IEN  = 12'h200;
  localparam logic [AW-1:0] A_DEC_STA  = 12'h204;

  typedef struct packed {
    logic ctl_we;
    logic cfg_we;
    logic ien_we;
    logic clr;
  } chan_wr_t;
endpackage

// File: rtl/ecc_chan.sv
module ecc_chan
  import ecc_regfront_pkg::*;
#(
  parameter int NSEC        = 4,
  parameter int STEP_CYCLES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  chan_wr_t        wr_i,
  input  logic [31:0]     wdata_i,
  output logic            run_o,
  output logic            busy_o,
  output logic [31:0]     cfg_o,
  output logic [1:0]      ien_o,
  output logic            pend_o,
  output logic [NSEC-1:0] done_o,
  output logic            fin_o
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic            run_q, busy_q, pend_q;
  logic [31:0]     cfg_q;
  logic [1:0]      ien_q;
  logic [NSEC-1:0] done_q;
  logic [SW-1:0]   sec_q;
  logic [CW-1:0]   cyc_q;

  logic step, last, start, stop;
  assign step  = busy_q && (cyc_q == CW'(STEP_CYCLES - 1));
  assign last  = (sec_q == SW'(NSEC - 1));
  assign start = wr_i.ctl_we && wdata_i[0] && !busy_q;
  assign stop  = wr_i.ctl_we && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cfg_q  <= '0;
      ien_q  <= '0;
      done_q <= '0;
      sec_q  <= '0;
      cyc_q  <= '0;
    end else begin
      if (start) begin
        run_q  <= 1'b1;
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        done_q <= '0;
        sec_q  <= '0;
        cyc_q  <= '0;
      end else if (stop) begin
        run_q  <= 1'b0;
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        sec_q  <= '0;
        cyc_q  <= '0;
      end else begin
        if (busy_q) cyc_q <= step ? '0 : cyc_q + 1'b1;
        if (step) begin
          for (int k = 0; k < NSEC; k++)
            if (sec_q == SW'(k)) done_q[k] <= 1'b1;
          if (last) busy_q <= 1'b0;
          else      sec_q  <= sec_q + 1'b1;
        end
        // set wins over a same-cycle read clear
        if (step && (!ien_q[1] || last)) pend_q <= 1'b1;
        else if (wr_i.clr)               pend_q <= 1'b0;
      end
      if (wr_i.cfg_we && !busy_q) cfg_q <= wdata_i;
      if (wr_i.ien_we)            ien_q <= wdata_i[1:0];
    end
  end

  assign run_o  = run_q;
  assign busy_o = busy_q;
  assign cfg_o  = cfg_q;
  assign ien_o  = ien_q;
  assign pend_o = pend_q;
  assign done_o = done_q;
  assign fin_o  = step && last;

  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cfg_q));
  p_mask_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (done_q == '0));
  p_mask_grow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (($past(done_q) & ~done_q) == '0));
  p_page_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pend_q) && $past(ien_q[1])) |-> done_q[NSEC-1]);
endmodule

// File: rtl/ecc_parity_stub.sv
module ecc_parity_stub #(
  parameter int NW  = 4,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic [31:0]   cfg_i,
  input  logic [IW-1:0] idx_i,
  output logic [31:0]   word_o
);
  logic [31:0] par_q [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      par_q[g] <= '0;
      else if (latch_i) par_q[g] <= cfg_i ^ (32'h0101_0101 * 32'(g + 1));
    end
  end

  assign word_o = par_q[idx_i];
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
  import ecc_regfront_pkg::*;
#(
  parameter int NUM_SECTORS = 4,
  parameter int STEP_CYCLES = 8,
  parameter int PAR_WORDS   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [11:0]   reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic [31:0]   enc_cfg_o,
  output logic [31:0]   dec_cfg_o
);
  localparam int PIW = (PAR_WORDS > 1) ? $clog2(PAR_WORDS) : 1;

  chan_wr_t enc_wr, dec_wr;
  logic enc_run, enc_busy, enc_pend, enc_fin;
  logic dec_run, dec_busy, dec_pend, dec_fin;
  logic [1:0] enc_ien, dec_ien;
  logic [0:0] enc_done;
  logic [NUM_SECTORS-1:0] dec_done;
  logic [31:0] par_word;
  logic [11:0] par_off;
  logic par_hit;

  always_comb begin
    enc_wr.ctl_we = reg_we_i && (reg_addr_i == A_ENC_CTL);
    enc_wr.cfg_we = reg_we_i && (reg_addr_i == A_ENC_CFG);
    enc_wr.ien_we = reg_we_i && (reg_addr_i == A_ENC_IEN);
    enc_wr.clr    = 1'b0;
    dec_wr.ctl_we = reg_we_i && (reg_addr_i == A_DEC_CTL);
    dec_wr.cfg_we = reg_we_i && (reg_addr_i == A_DEC_CFG);
    dec_wr.ien_we = reg_we_i && (reg_addr_i == A_DEC_IEN);
    dec_wr.clr    = reg_re_i && ((reg_addr_i == A_DEC_STA) || (reg_addr_i == A_DEC_DONE));
  end

  ecc_chan #(.NSEC(1), .STEP_CYCLES(STEP_CYCLES)) u_enc (
    .clk_i, .rst_ni, .wr_i(enc_wr), .wdata_i(reg_wdata_i),
    .run_o(enc_run), .busy_o(enc_busy), .cfg_o(enc_cfg_o), .ien_o(enc_ien),
    .pend_o(enc_pend), .done_o(enc_done), .fin_o(enc_fin)
  );

  ecc_chan #(.NSEC(NUM_SECTORS), .STEP_CYCLES(STEP_CYCLES)) u_dec (
    .clk_i, .rst_ni, .wr_i(dec_wr), .wdata_i(reg_wdata_i),
    .run_o(dec_run), .busy_o(dec_busy), .cfg_o(dec_cfg_o), .ien_o(dec_ien),
    .pend_o(dec_pend), .done_o(dec_done), .fin_o(dec_fin)
  );

  assign par_off = reg_addr_i - A_ENC_PAR;
  assign par_hit = (reg_addr_i >= A_ENC_PAR) && (par_off < 12'(4 * PAR_WORDS));

  ecc_parity_stub #(.NW(PAR_WORDS)) u_par (
    .clk_i, .rst_ni, .latch_i(enc_fin), .cfg_i(enc_cfg_o),
    .idx_i(par_off[PIW+1:2]), .word_o(par_word)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (par_hit) reg_rdata_o = par_word;
    else begin
      case (reg_addr_i)
        A_ENC_CTL:  reg_rdata_o = {31'd0, enc_run};
        A_ENC_CFG:  reg_rdata_o = enc_cfg_o;
        A_ENC_IDLE: reg_rdata_o = {30'd0, enc_done[0], !enc_busy};
        A_ENC_IEN:  reg_rdata_o = {30'd0, enc_ien};
        A_ENC_STA:  reg_rdata_o = {31'd0, enc_pend};
        A_DEC_CTL:  reg_rdata_o = {31'd0, dec_run};
        A_DEC_CFG:  reg_rdata_o = dec_cfg_o;
        A_DEC_IDLE: reg_rdata_o = {31'd0, !dec_busy};
        A_DEC_DONE: reg_rdata_o = 32'(dec_done);
        A_DEC_IEN:  reg_rdata_o = {30'd0, dec_ien};
        A_DEC_STA:  reg_rdata_o = {31'd0, dec_pend};
        default:    reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (enc_ien[0] && enc_pend) || (dec_ien[0] && dec_pend);

  p_irq_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (enc_pend || dec_pend));
  p_fin_unique_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_fin |=> !enc_busy);
endmodule

// File: tb/ecc_regfront_tb.sv
module ecc_regfront_tb;
  import ecc_regfront_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, enc_cfg, dec_cfg;
  logic irq;
  int checks = 0, errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ecc_regfront u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .enc_cfg_o(enc_cfg), .dec_cfg_o(dec_cfg)
  );

  // monitor: pops expected read data as each read is presented
  always @(negedge clk) begin
    if (re) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%h got=%h exp=%h", t, addr, rdata, e);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1 addr = a; re = 1'b1;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", t, got, e);
    end
  endtask

  task automatic wait_irq(input string t);
    int n = 0;
    while (!irq && n < 300) begin @(negedge clk); n++; end
    chk({31'd0, irq}, 32'd1, t);
  endtask

  localparam logic [31:0] DCFG = 32'h9070_3043;
  localparam logic [31:0] ECFG = 32'h1000_0045;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({31'd0, irq}, 0, "R1 irq");
    chk(dec_cfg, 0, "R1 dec_cfg");
    chk(enc_cfg, 0, "R1 enc_cfg");
    rd(A_ENC_IDLE, 1, "R1 enc idle");
    rd(A_DEC_IDLE, 1, "R1 dec idle");
    rd(A_DEC_CTL, 0, "R1 dec ctl");
    rd(A_DEC_STA, 0, "R1 dec sta");
    rd(A_DEC_DONE, 0, "R1 done");
    rd(A_ENC_PAR, 0, "R1 parity");

    // R3 configuration storage
    wr(A_DEC_CFG, DCFG);
    rd(A_DEC_CFG, DCFG, "R3 dec cfg readback");
    @(negedge clk); chk(dec_cfg, DCFG, "R3 dec_cfg_o");

    // per-step decode interrupts
    wr(A_DEC_IEN, 32'h1);
    wr(A_DEC_CTL, 1);
    rd(A_DEC_IDLE, 0, "R2 busy after start");
    wait_irq("R7 step irq");
    rd(A_DEC_DONE, 32'h1, "R5 first sector");
    @(negedge clk); chk({31'd0, irq}, 0, "R8 done read clears");
    wr(A_DEC_CFG, 32'h1);
    rd(A_DEC_CFG, DCFG, "R4 cfg ignored busy");
    wait_irq("R7 second step irq");
    rd(A_DEC_STA, 1, "R8 sta pending");
    rd(A_DEC_STA, 0, "R8 sta cleared");
    repeat (24) @(posedge clk);
    rd(A_DEC_IDLE, 1, "R5 idle at end");
    rd(A_DEC_DONE, 32'hF, "R5 all sectors");
    rd(A_DEC_CTL, 1, "R2 ctl stays set");

    // page mode
    wr(A_DEC_IEN, 32'h3);
    wr(A_DEC_CTL, 1);
    repeat (26) @(posedge clk);
    rd(A_DEC_DONE, 32'h7, "R5 three sectors");
    @(negedge clk); chk({31'd0, irq}, 0, "R7 page no early irq");
    wait_irq("R7 page irq");
    rd(A_DEC_DONE, 32'hF, "R7 page irq at last");

    // enable gating
    wr(A_DEC_IEN, 32'h0);
    wr(A_DEC_CTL, 1);
    repeat (40) @(posedge clk);
    @(negedge clk); chk({31'd0, irq}, 0, "R6 disabled no irq");
    wr(A_DEC_IEN, 32'h1);
    @(negedge clk); chk({31'd0, irq}, 1, "R6 late enable fires");
    rd(A_DEC_STA, 1, "R6 sta pending");
    @(negedge clk); chk({31'd0, irq}, 0, "R8 irq cleared");

    // abort
    wr(A_DEC_CTL, 1);
    rd(A_DEC_IDLE, 0, "R2 busy");
    wr(A_DEC_CTL, 0);
    rd(A_DEC_IDLE, 1, "R2 idle after stop");
    rd(A_DEC_CTL, 0, "R2 ctl after stop");
    repeat (20) @(posedge clk);
    rd(A_DEC_DONE, 0, "R5 mask cleared on start, no progress");

    // encoder
    wr(A_ENC_CFG, ECFG);
    wr(A_ENC_IEN, 32'h1);
    wr(A_ENC_CTL, 1);
    rd(A_ENC_IDLE, 0, "R2 enc busy");
    wait_irq("R9 enc irq");
    rd(A_ENC_STA, 1, "R9 enc sta");
    rd(A_ENC_STA, 1, "R9 enc sta sticky");
    rd(A_ENC_IDLE, 3, "R9 enc idle and finished");
    for (int i = 0; i < 4; i++)
      rd(A_ENC_PAR + 12'(4 * i), ECFG ^ (32'h0101_0101 * 32'(i + 1)), "R9 parity");
    wr(A_ENC_CTL, 0);
    @(negedge clk); chk({31'd0, irq}, 0, "R9 stop clears irq");
    rd(A_ENC_STA, 0, "R9 sta cleared on stop");

    repeat (2) @(posedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule